// File: doc/BRIEF.md
# Open-Loop Phase Detector with Half-Cycle Flag

This block compares two single-bit clocks, A and B, that are sampled in a faster system clock domain. It derives their phase relation without any reset feedback path. A hold element called the lag signal is set when both sampled inputs are low and cleared when both are high. It keeps its value while the inputs differ. Each sampled input is delayed by one system clock so that it lines up with the lag signal. The aligned copies are then compared with lag to produce the UP and DN steering outputs.

When A and B are half a period apart, lag carries no usable phase information. A second path covers this case. It makes a one-cycle pulse on each rising edge of A and on each falling edge of B. If the two pulses fall within a programmable window of 1 to 3 system clocks, it raises a one-cycle half-cycle flag. The downstream pump uses that flag to resolve the ambiguity.

Top module: `phase_det_oloop`

## Requirements
- R1: While reset is asserted, `lag`, `up`, `dn` and `pi_det` are all 0. Reset also clears the input sample stages and the edge history.
- R2: If both inputs are sampled low at clock edge k, `lag` is 1 after edge k+1.
- R3: If both inputs are sampled high at clock edge k, `lag` is 0 after edge k+1.
- R4: If the inputs are sampled with different values at edge k, `lag` keeps its value across edge k+1.
- R5: `up` is 1 exactly when the copy of A sampled one edge earlier is 1 and `lag` is 0. An input change made before edge k therefore reaches `up` after edge k+1.
- R6: `dn` is 1 exactly when the copy of B sampled one edge earlier is 1 and `lag` is 1. It has the same two-edge latency as `up`.
- R7: An A rising edge and a B falling edge that land on the same sample edge give a one-cycle `pi_det` pulse. This holds for every window setting, and the pulse appears two edges after the inputs are driven.
- R8: With window W, `pi_det` pulses when an A rise and a B fall are less than W sample edges apart, in either order. Nothing is flagged when they are W or more edges apart.
- R9: `win_sel` = 0 behaves as a window of 1. The values 1, 2 and 3 select windows of 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 1 | First compared clock (reference side) |
| b_in | input | 1 | Second compared clock (feedback side) |
| win_sel | input | 2 | Coincidence window in system clocks (0 is treated as 1) |
| up | output | 1 | Steer-up request |
| dn | output | 1 | Steer-down request |
| lag | output | 1 | Hold-when-different lag signal |
| pi_det | output | 1 | Half-cycle coincidence pulse |

## Verification
Every output is due two rising edges after the input change that causes it. One edge samples the input, and a second edge updates `lag`, the aligned copy and the `pi_det` register. The bench drives inputs just after a falling edge and reads the outputs at the following falling edge, which is one rising edge later. Its reference model holds a matching two-stage view of the stimulus history, so each expectation is compared in the cycle it is due. The R8 window tests place an A rise and a B fall a known number of edges apart and record whether `pi_det` appears within the following few cycles.

// File: rtl/pd_oloop_pkg.sv
package pd_oloop_pkg;

    // One sample of both compared inputs.
    typedef struct packed {
        logic a;
        logic b;
    } pd_pair_t;

    // Number of system clocks of input alignment, equal to the lag-cell latency.
    localparam int unsigned PD_ALIGN_STAGES = 1;

endpackage

// File: rtl/pd_sampler.sv
module pd_sampler
    import pd_oloop_pkg::*;
#(
    parameter int unsigned ALIGN = PD_ALIGN_STAGES
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     a_in,
    input  logic     b_in,
    output pd_pair_t smp,
    output pd_pair_t aln
);

    localparam int unsigned NSTG = (ALIGN < 1) ? 1 : ALIGN;

    typedef struct packed {
        pd_pair_t            smp;
        pd_pair_t [NSTG-1:0] dly;
    } smp_state_t;

    smp_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.smp.a = a_in;
        st_d.smp.b = b_in;
        st_d.dly[0] = st_q.smp;
        for (int i = 1; i < int'(NSTG); i++) begin
            st_d.dly[i] = st_q.dly[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp = st_q.smp;
    assign aln = st_q.dly[NSTG-1];

    // R5: the aligned copy is the sample taken one edge earlier.
    a_r5_align_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (NSTG == 1) |=> (aln == $past(smp)));

endmodule

// File: rtl/pd_lag_cell.sv
module pd_lag_cell
    import pd_oloop_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pd_pair_t smp,
    output logic     lag
);

    typedef struct packed {
        logic lag;
    } lag_state_t;

    lag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({smp.a, smp.b})
            2'b00:   st_d.lag = 1'b1;
            2'b11:   st_d.lag = 1'b0;
            default: st_d.lag = st_q.lag;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lag = st_q.lag;

    a_r2_lag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp.a && !smp.b) |=> lag);

    a_r3_lag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (smp.a && smp.b) |=> !lag);

    a_r4_lag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (smp.a != smp.b) |=> $stable(lag));

endmodule

// File: rtl/pd_pi_detect.sv
module pd_pi_detect
    import pd_oloop_pkg::*;
#(
    parameter int unsigned MAX_WIN = 3,
    localparam int unsigned WIN_W  = $clog2(MAX_WIN + 1),
    localparam int unsigned HIST   = (MAX_WIN > 1) ? (MAX_WIN - 1) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pd_pair_t         smp,
    input  pd_pair_t         aln,
    input  logic [WIN_W-1:0] win_sel,
    output logic             pi
);

    typedef struct packed {
        logic [HIST-1:0] a_hist;
        logic [HIST-1:0] b_hist;
        logic            pi;
    } pi_state_t;

    pi_state_t        st_d, st_q;
    logic             a_rise, b_fall;
    logic [WIN_W-1:0] eff_win;
    logic [HIST-1:0]  win_mask;
    logic             a_recent, b_recent;

    // One-cycle edge pulses from the sample stage and its aligned copy.
    assign a_rise = smp.a & ~aln.a;
    assign b_fall = ~smp.b & aln.b;

    always_comb begin
        if (win_sel == '0) begin
            eff_win = WIN_W'(1);
        end else if (int'(win_sel) > int'(MAX_WIN)) begin
            eff_win = WIN_W'(MAX_WIN);
        end else begin
            eff_win = win_sel;
        end
        for (int i = 0; i < int'(HIST); i++) begin
            win_mask[i] = (i < (int'(eff_win) - 1));
        end
    end

    assign a_recent = |(st_q.a_hist & win_mask);
    assign b_recent = |(st_q.b_hist & win_mask);

    always_comb begin
        st_d    = st_q;
        st_d.pi = (a_rise & (b_fall | b_recent)) | (b_fall & a_recent);
        if (HIST > 1) begin
            st_d.a_hist = {st_q.a_hist[HIST-2:0], a_rise};
            st_d.b_hist = {st_q.b_hist[HIST-2:0], b_fall};
        end else begin
            st_d.a_hist[0] = a_rise;
            st_d.b_hist[0] = b_fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pi = st_q.pi;

    // R7: a flag is always caused by one of the two edge pulses in the previous cycle.
    a_r7_pi_has_edge: assert property (@(posedge clk) disable iff (!rst_n)
        pi |-> $past(a_rise || b_fall));

    // R9: the effective window never falls outside 1..MAX_WIN.
    a_r9_window_range: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_win != '0) && (int'(eff_win) <= int'(MAX_WIN)));

endmodule

// File: rtl/phase_det_oloop.sv
module phase_det_oloop
    import pd_oloop_pkg::*;
#(
    parameter int unsigned MAX_WIN = 3,
    localparam int unsigned WIN_W  = $clog2(MAX_WIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_in,
    input  logic             b_in,
    input  logic [WIN_W-1:0] win_sel,
    output logic             up,
    output logic             dn,
    output logic             lag,
    output logic             pi_det
);

    pd_pair_t smp, aln;
    logic     lag_w, pi_w;

    pd_sampler #(.ALIGN(PD_ALIGN_STAGES)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .a_in  (a_in),
        .b_in  (b_in),
        .smp   (smp),
        .aln   (aln)
    );

    pd_lag_cell u_lag (
        .clk   (clk),
        .rst_n (rst_n),
        .smp   (smp),
        .lag   (lag_w)
    );

    pd_pi_detect #(.MAX_WIN(MAX_WIN)) u_pi (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp     (smp),
        .aln     (aln),
        .win_sel (win_sel),
        .pi      (pi_w)
    );

    assign up     = aln.a & ~lag_w;
    assign dn     = aln.b & lag_w;
    assign lag    = lag_w;
    assign pi_det = pi_w;

    // R1: one edge under reset leaves every output at zero.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!lag && !up && !dn && !pi_det));

    // R5/R6: a steering output is driven only by an input sampled high one edge before.
    a_r5_up_source: assert property (@(posedge clk) disable iff (!rst_n)
        up |-> $past(smp.a));

    a_r6_dn_source: assert property (@(posedge clk) disable iff (!rst_n)
        dn |-> $past(smp.b));

endmodule

// File: tb/phase_det_oloop_bench.sv
`timescale 1ns/1ps
module phase_det_oloop_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_in = 1'b0, b_in = 1'b0;
    logic [1:0] win_sel = 2'd1;
    logic       up, dn, lag, pi_det;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    logic msa, msb, mda, mdb, mlag, mpi;
    logic [2:0] arh, brh;
    logic pi_seen;

    always #2 clk = ~clk;

    phase_det_oloop u_phase_det_oloop (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .win_sel(win_sel),
        .up(up), .dn(dn), .lag(lag), .pi_det(pi_det)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_w();
        return (win_sel == 2'd0) ? 1 : int'(win_sel);
    endfunction

    task automatic model_reset();
        msa = 0; msb = 0; mda = 0; mdb = 0; mlag = 0; mpi = 0;
        arh = '0; brh = '0;
    endtask

    // Drive one input pair, advance one edge, check at the next falling edge.
    task automatic step(input logic a, input logic b);
        logic osa, osb, oda, odb, ar, bf, arec, brec;
        int   w;
        a_in = a; b_in = b;
        @(posedge clk);
        osa = msa; osb = msb; oda = mda; odb = mdb;
        if (!osa && !osb)     mlag = 1'b1;
        else if (osa && osb)  mlag = 1'b0;
        mda = osa; mdb = osb; msa = a; msb = b;
        ar = osa & ~oda;
        bf = ~osb & odb;
        w = eff_w();
        arec = 1'b0; brec = 1'b0;
        for (int i = 0; i < w - 1; i++) begin
            arec |= arh[i];
            brec |= brh[i];
        end
        mpi = (ar & (bf | brec)) | (bf & arec);
        arh = {arh[1:0], ar};
        brh = {brh[1:0], bf};
        @(negedge clk);
        chk("R2/R3/R4 lag", lag, mlag);
        chk("R5 up", up, mda & ~mlag);
        chk("R6 dn", dn, mdb & mlag);
        chk("R7/R8/R9 pi_det", pi_det, mpi);
        pi_seen |= pi_det;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        pi_seen = 1'b0;
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        chk("R1 lag", lag, 1'b0);
        chk("R1 up", up, 1'b0);
        chk("R1 dn", dn, 1'b0);
        chk("R1 pi_det", pi_det, 1'b0);
        rst_n = 1'b1;

        // Near-exhaustive sweep of all 4-step input sequences, per window setting (R2..R9)
        for (int ws = 0; ws < 4; ws++) begin
            win_sel = 2'(ws);
            for (int seq = 0; seq < 256; seq++) begin
                for (int k = 0; k < 4; k++) begin
                    step(seq[2*k], seq[2*k+1]);
                end
            end
        end

        // Phase sweep: square waves of period 8 with every offset; offset 4 is half-cycle (R7)
        for (int ws = 0; ws < 4; ws++) begin
            win_sel = 2'(ws);
            for (int off = 0; off < 8; off++) begin
                pi_seen = 1'b0;
                for (int t = 0; t < 32; t++) begin
                    step(((t % 8) < 4), (((t + off) % 8) < 4));
                end
                if (off == 4) chk("R7 half-cycle flagged", pi_seen, 1'b1);
            end
        end

        // R8/R9: separation of A-rise and B-fall against the window, both orders
        for (int ws = 0; ws < 4; ws++) begin
            win_sel = 2'(ws);
            for (int sep = 0; sep < 4; sep++) begin
                for (int ord = 0; ord < 2; ord++) begin
                    int ta, tb;
                    ta = (ord == 0) ? 0 : sep;
                    tb = (ord == 0) ? sep : 0;
                    repeat (5) step(1'b0, 1'b1);
                    pi_seen = 1'b0;
                    for (int i = 0; i < sep + 5; i++) begin
                        step(i >= ta, !(i >= tb));
                    end
                    chk("R8 window separation", pi_seen, (sep < eff_w()) ? 1'b1 : 1'b0);
                    if (ws == 0) chk("R9 zero setting acts as one", pi_seen, (sep == 0) ? 1'b1 : 1'b0);
                end
            end
        end

        // R1: reset in mid-run clears everything
        a_in = 1'b1; b_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 lag after reset", lag, 1'b0);
        chk("R1 up after reset", up, 1'b0);
        chk("R1 dn after reset", dn, 1'b0);
        chk("R1 pi_det after reset", pi_det, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule